// File: doc/BRIEF.md
# Reservation Tracker for Reserve-Load and Conditional-Store

This block holds the single memory reservation that a one-core processor needs for its atomic read-modify-write sequences. The load/store unit presents one request per cycle: a reserve-load, a conditional-store, a plain store or an invalidate. Each request carries an effective address, an access size of 1, 2, 4 or 8 bytes and, for stores, the data. One cycle later the block answers. It gives a memory write with byte lanes already placed, a condition-register image whose EQ bit of field 0 reports whether a conditional-store succeeded, or an alignment-exception request with its vector offset.

A reservation covers one 8-byte granule. A reserve-load sets it. Any conditional-store, a plain store that hits the granule or an explicit invalidate (for instance on interrupt entry) removes it. Misaligned reserve and conditional accesses are refused with the alignment vector and leave the reservation as it was.

Top module: `resv_unit`

## Requirements
- R1: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high. A new request may be accepted every cycle. With no request, the next cycle shows `wr_en`, `cc_valid` and `align_exc` low.
- R2: `req_size` codes 0,1,2,3 mean 1,2,4,8 bytes. `req_op` codes are 0 reserve-load, 1 conditional-store, 2 plain store, 3 invalidate. An access is misaligned when `req_addr & (bytes-1)` is non-zero.
- R3: A misaligned reserve-load or conditional-store gives `align_exc`=1 with `exc_vec`=0x600, no write, `cc_valid`=0, and leaves the reservation unchanged.
- R4: A naturally aligned reserve-load or conditional-store never raises `align_exc`. Plain stores and invalidates never raise it.
- R5: An aligned reserve-load makes the reservation valid for granule `req_addr[AW-1:3]`. Any size and offset within that granule matches it.
- R6: An aligned conditional-store succeeds only if a reservation is valid for its granule. It then gives `cc_valid`=1, `cr0_image`=0x20000000 and a write of the requested size. On failure it gives `cc_valid`=1, `cr0_image`=0 and no write.
- R7: Every aligned conditional-store, successful or not, removes the reservation.
- R8: A plain store always writes. It removes the reservation only when its granule matches.
- R9: An invalidate removes the reservation and produces no write.
- R10: A write carries `wr_addr`=`req_addr[AW-1:3]` and `wr_mask`=((1<<bytes)-1)<<`req_addr[2:0]`. Data byte k goes to lane `req_addr[2:0]`+k, and unselected lanes read zero.
- R11: After reset no reservation is held and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (R2) |
| req_addr | input | AW | Effective byte address |
| req_size | input | 2 | Access size code (R2) |
| req_data | input | DW | Store data, value in low bytes |
| resp_valid | output | 1 | Response for last cycle's request |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | AW-3 | Granule address of the write |
| wr_mask | output | DW/8 | Byte-lane enables |
| wr_data | output | DW | Lane-placed write data |
| cc_valid | output | 1 | Conditional-store outcome is present |
| cr0_image | output | 32 | Condition-register image, EQ at mask 0x20000000 |
| align_exc | output | 1 | Alignment-exception request |
| exc_vec | output | 12 | Exception vector offset |

## Verification
The bench aims at the alignment boundary for each size. A wrong mask would either trap aligned halfword and word reservations or let a straddling doubleword through. It also checks that a refused conditional-store keeps the reservation: a design that cleared it would fail the aligned retry that follows. Back-to-back conditional-stores, a plain store to a neighbouring granule versus the same granule, and an invalidate between a reserve and a conditional-store show whether the reservation is dropped too eagerly or kept too long. A behavioural memory fed only by the write port shows misplaced byte lanes.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        OP_RSV_LOAD   = 2'd0,
        OP_COND_STORE = 2'd1,
        OP_PLAIN_STORE= 2'd2,
        OP_DROP_RSV   = 2'd3
    } resv_op_e;

    localparam logic [11:0] ALIGN_VECTOR = 12'h600;
    localparam logic [31:0] CR0_EQ_MASK  = 32'h2000_0000;
endpackage

// File: rtl/resv_align.sv
module resv_align #(
    parameter int LB = 3
) (
    input  logic [LB-1:0] low_i,
    input  logic [1:0]    size_i,
    output logic          misaligned_o
);
    logic [LB-1:0] bad;

    // bit i of the offset must be zero whenever the access spans more than 2**i bytes
    for (genvar i = 0; i < LB; i++) begin : g_bit
        assign bad[i] = low_i[i] && (int'(size_i) > i);
    end

    assign misaligned_o = |bad;
endmodule

// File: rtl/resv_lanes.sv
module resv_lanes #(
    parameter int DW = 64,
    parameter int LB = 3
) (
    input  logic [LB-1:0]   low_i,
    input  logic [1:0]      size_i,
    input  logic [DW-1:0]   data_i,
    output logic [DW/8-1:0] mask_o,
    output logic [DW-1:0]   data_o
);
    localparam int NB = DW / 8;

    logic [DW-1:0] shifted;
    int            nbytes;

    assign nbytes  = 1 << size_i;
    assign shifted = data_i << {low_i, 3'b000};

    for (genvar j = 0; j < NB; j++) begin : g_lane
        assign mask_o[j]          = (j >= int'(low_i)) && (j < int'(low_i) + nbytes);
        assign data_o[8*j +: 8]   = mask_o[j] ? shifted[8*j +: 8] : 8'h00;
    end
endmodule

// File: rtl/resv_track.sv
module resv_track #(
    parameter int GW = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic [GW-1:0] set_granule_i,
    input  logic          clear_i,
    output logic          valid_o,
    output logic [GW-1:0] granule_o
);
    typedef struct packed {
        logic          valid;
        logic [GW-1:0] granule;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.valid = 1'b0;
        end
        if (set_i) begin
            st_d.valid   = 1'b1;
            st_d.granule = set_granule_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = st_q.valid;
    assign granule_o = st_q.granule;
endmodule

// File: rtl/resv_unit.sv
module resv_unit #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [AW-1:0]                req_addr,
    input  logic [1:0]                   req_size,
    input  logic [DW-1:0]                req_data,
    output logic                         resp_valid,
    output logic                         wr_en,
    output logic [AW-$clog2(DW/8)-1:0]   wr_addr,
    output logic [DW/8-1:0]              wr_mask,
    output logic [DW-1:0]                wr_data,
    output logic                         cc_valid,
    output logic [31:0]                  cr0_image,
    output logic                         align_exc,
    output logic [11:0]                  exc_vec
);
    import resv_pkg::*;

    localparam int NB = DW / 8;
    localparam int LB = $clog2(NB);
    localparam int GW = AW - LB;

    typedef struct packed {
        logic          resp_valid;
        logic          wr_en;
        logic [GW-1:0] wr_addr;
        logic [NB-1:0] wr_mask;
        logic [DW-1:0] wr_data;
        logic          cc_valid;
        logic [31:0]   cr0_image;
        logic          align_exc;
        logic [11:0]   exc_vec;
    } resp_t;

    resp_t out_d, out_q;

    logic          misaligned;
    logic [NB-1:0] lane_mask;
    logic [DW-1:0] lane_data;
    logic          rsv_valid;
    logic [GW-1:0] rsv_granule;
    logic          rsv_set, rsv_clear;
    logic [GW-1:0] req_granule;
    logic          granule_hit;
    resv_op_e      op;

    assign op          = resv_op_e'(req_op);
    assign req_granule = req_addr[AW-1:LB];
    assign granule_hit = rsv_valid && (rsv_granule == req_granule);

    resv_align #(.LB(LB)) u_align (
        .low_i        (req_addr[LB-1:0]),
        .size_i       (req_size),
        .misaligned_o (misaligned)
    );

    resv_lanes #(.DW(DW), .LB(LB)) u_lanes (
        .low_i  (req_addr[LB-1:0]),
        .size_i (req_size),
        .data_i (req_data),
        .mask_o (lane_mask),
        .data_o (lane_data)
    );

    resv_track #(.GW(GW)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_i         (rsv_set),
        .set_granule_i (req_granule),
        .clear_i       (rsv_clear),
        .valid_o       (rsv_valid),
        .granule_o     (rsv_granule)
    );

    always_comb begin
        out_d     = '0;
        rsv_set   = 1'b0;
        rsv_clear = 1'b0;
        if (req_valid) begin
            out_d.resp_valid = 1'b1;
            unique case (op)
                OP_RSV_LOAD: begin
                    if (misaligned) begin
                        out_d.align_exc = 1'b1;
                        out_d.exc_vec   = ALIGN_VECTOR;
                    end else begin
                        rsv_set = 1'b1;
                    end
                end
                OP_COND_STORE: begin
                    if (misaligned) begin
                        out_d.align_exc = 1'b1;
                        out_d.exc_vec   = ALIGN_VECTOR;
                    end else begin
                        rsv_clear      = 1'b1;
                        out_d.cc_valid = 1'b1;
                        if (granule_hit) begin
                            out_d.wr_en     = 1'b1;
                            out_d.cr0_image = CR0_EQ_MASK;
                        end
                    end
                end
                OP_PLAIN_STORE: begin
                    out_d.wr_en = 1'b1;
                    rsv_clear   = granule_hit;
                end
                OP_DROP_RSV: begin
                    rsv_clear = 1'b1;
                end
                default: ;
            endcase
            if (out_d.wr_en) begin
                out_d.wr_addr = req_granule;
                out_d.wr_mask = lane_mask;
                out_d.wr_data = lane_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign resp_valid = out_q.resp_valid;
    assign wr_en      = out_q.wr_en;
    assign wr_addr    = out_q.wr_addr;
    assign wr_mask    = out_q.wr_mask;
    assign wr_data    = out_q.wr_data;
    assign cc_valid   = out_q.cc_valid;
    assign cr0_image  = out_q.cr0_image;
    assign align_exc  = out_q.align_exc;
    assign exc_vec    = out_q.exc_vec;
endmodule

// File: rtl/resv_unit_chk.sv
module resv_unit_chk #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [1:0]                 req_op,
    input logic [AW-1:0]              req_addr,
    input logic [1:0]                 req_size,
    input logic                       resp_valid,
    input logic                       wr_en,
    input logic                       cc_valid,
    input logic [31:0]                cr0_image,
    input logic                       align_exc,
    input logic [11:0]                exc_vec
);
    logic [3:0] size_bytes;
    logic       req_mis;
    logic       req_atomic;
    logic       req_sc_ok;

    assign size_bytes = 4'd1 << req_size;
    assign req_mis    = (req_addr[3:0] & (size_bytes - 4'd1)) != 4'd0;
    assign req_atomic = req_valid && (req_op == 2'd0 || req_op == 2'd1);
    assign req_sc_ok  = req_valid && req_op == 2'd1 && !req_mis;

    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid && !wr_en && !cc_valid && !align_exc);
    a_r3_vector_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        align_exc |-> exc_vec == 12'h600 && !wr_en && !cc_valid);
    a_r3_misaligned_traps: assert property (@(posedge clk) disable iff (!rst_n)
        req_atomic && req_mis |=> align_exc);
    a_r4_aligned_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(req_atomic && req_mis) |=> !align_exc);
    a_r6_success_writes: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid && cr0_image == 32'h2000_0000 |-> wr_en);
    a_r6_failure_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid && cr0_image == 32'h0 |-> !wr_en);
    a_r6_only_eq_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0_image & ~32'h2000_0000) == 32'h0);
    a_r7_second_sc_fails: assert property (@(posedge clk) disable iff (!rst_n)
        req_sc_ok ##1 req_sc_ok |=> cc_valid && cr0_image == 32'h0);
endmodule

bind resv_unit resv_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .resp_valid (resp_valid),
    .wr_en      (wr_en),
    .cc_valid   (cc_valid),
    .cr0_image  (cr0_image),
    .align_exc  (align_exc),
    .exc_vec    (exc_vec)
);

// File: tb/sim_resv_unit.sv
`timescale 1ns/1ps
module sim_resv_unit;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic [DW-1:0] req_data = '0;
    logic          resp_valid, wr_en, cc_valid, align_exc;
    logic [AW-4:0] wr_addr;
    logic [7:0]    wr_mask;
    logic [DW-1:0] wr_data;
    logic [31:0]   cr0_image;
    logic [11:0]   exc_vec;

    always #2.5 clk = ~clk;

    resv_unit #(.AW(AW), .DW(DW)) u0 (.*);

    int nchk = 0, nfail = 0;
    logic          m_rv = 1'b0;
    logic [AW-4:0] m_rg = '0;
    logic [63:0]   emem [16];
    logic [63:0]   dmem [16];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive one request; outputs checked at the following falling edge
    task automatic issue(string tag, int op, logic [AW-1:0] addr, int sz, logic [63:0] data);
        logic        mis, hit, e_exc, e_cc, e_wr;
        logic [31:0] e_cr;
        logic [7:0]  e_mask;
        logic [63:0] e_data;
        int          nb, low;
        nb  = 1 << sz;
        low = int'(addr[2:0]);
        mis = (addr & AW'(nb - 1)) != '0;
        hit = m_rv && (m_rg == addr[AW-1:3]);
        e_exc = 1'b0; e_cc = 1'b0; e_wr = 1'b0; e_cr = 32'h0;
        e_mask = '0; e_data = '0;
        for (int k = 0; k < nb; k++) begin
            if (low + k < 8) begin
                e_mask[low+k] = 1'b1;
                e_data[8*(low+k) +: 8] = data[8*k +: 8];
            end
        end
        req_valid = 1'b1; req_op = 2'(op); req_addr = addr;
        req_size = 2'(sz); req_data = data;
        @(negedge clk);
        case (op)
            0: if (mis) e_exc = 1'b1; else begin m_rv = 1'b1; m_rg = addr[AW-1:3]; end
            1: if (mis) e_exc = 1'b1;
               else begin e_cc = 1'b1; e_wr = hit; e_cr = hit ? 32'h2000_0000 : 32'h0; m_rv = 1'b0; end
            2: begin e_wr = 1'b1; if (hit) m_rv = 1'b0; end
            default: m_rv = 1'b0;
        endcase
        chk({tag, " R1 resp_valid"}, 64'(resp_valid), 64'd1);
        chk({tag, " R3/R4 align_exc"}, 64'(align_exc), 64'(e_exc));
        if (e_exc) chk({tag, " R3 exc_vec"}, 64'(exc_vec), 64'h600);
        chk({tag, " R6 cc_valid"}, 64'(cc_valid), 64'(e_cc));
        chk({tag, " R6 cr0_image"}, 64'(cr0_image), 64'(e_cr));
        chk({tag, " R6/R8 wr_en"}, 64'(wr_en), 64'(e_wr));
        if (e_wr) begin
            chk({tag, " R10 wr_addr"}, 64'(wr_addr), 64'(addr[AW-1:3]));
            chk({tag, " R10 wr_mask"}, 64'(wr_mask), 64'(e_mask));
            chk({tag, " R10 wr_data"}, wr_data, e_data);
            for (int b = 0; b < 8; b++)
                if (e_mask[b]) emem[addr[6:3]][8*b +: 8] = e_data[8*b +: 8];
        end
        if (wr_en)
            for (int b = 0; b < 8; b++)
                if (wr_mask[b]) dmem[wr_addr[3:0]][8*b +: 8] = wr_data[8*b +: 8];
        if (e_cc && e_wr) chk({tag, " R6 memory"}, dmem[addr[6:3]], emem[addr[6:3]]);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle resp_valid", 64'(resp_valid), 64'd0);
        chk("R1 idle wr_en", 64'(wr_en), 64'd0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin emem[i] = '0; dmem[i] = '0; end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 resp_valid", 64'(resp_valid), 64'd0);
        chk("R11 cr0_image", 64'(cr0_image), 64'd0);
        chk("R11 align_exc", 64'(align_exc), 64'd0);
        rst_n = 1'b1;
        issue("R11 sc after reset", 1, 32'h40, 3, 64'h11);
        // R6: success for each size
        for (int s = 0; s < 4; s++) begin
            issue("R6 lr", 0, 32'h20, s, 64'h0);
            issue("R6 sc ok", 1, 32'h20, s, 64'h1122_3344_5566_7788 + 64'(s));
            issue("R7 sc again", 1, 32'h20, s, 64'hdead);
        end
        // R2/R3: misaligned per size, reservation kept
        for (int s = 1; s < 4; s++) begin
            for (int off = 1; off < (1 << s); off++) begin
                issue("R5 lr", 0, 32'h30, 0, 64'h0);
                issue("R3 lr mis", 0, 32'h50 + 32'(off), s, 64'h0);
                issue("R3 sc mis", 1, 32'h30 + 32'(off), s, 64'h0);
                issue("R3 kept sc", 1, 32'h30, 0, 64'h5a);
            end
        end
        // R4: aligned every offset
        for (int s = 0; s < 4; s++)
            for (int off = 0; off < 16; off += (1 << s))
                issue("R4 lr aligned", 0, 32'h60 + 32'(off), s, 64'h0);
        // R5: granule-level match
        issue("R5 lr", 0, 32'h12, 1, 64'h0);
        issue("R5 sc same granule", 1, 32'h14, 2, 64'hcafe_f00d);
        issue("R5 lr", 0, 32'h12, 1, 64'h0);
        issue("R5 sc next granule", 1, 32'h18, 2, 64'hbeef);
        // R8: plain store neighbour vs same granule
        issue("R8 lr", 0, 32'h08, 3, 64'h0);
        issue("R8 st other", 2, 32'h10, 3, 64'h77);
        issue("R8 sc kept", 1, 32'h08, 3, 64'h99);
        issue("R8 lr", 0, 32'h08, 3, 64'h0);
        issue("R8 st same", 2, 32'h0c, 2, 64'h66);
        issue("R8 sc lost", 1, 32'h08, 3, 64'h99);
        // R9: invalidate
        issue("R9 lr", 0, 32'h28, 3, 64'h0);
        issue("R9 drop", 3, 32'h0, 0, 64'h0);
        issue("R9 sc lost", 1, 32'h28, 3, 64'h1);
        idle();
        // random mix
        begin
            logic [AW-1:0] last_lr = 32'h0;
            for (int n = 0; n < 4000; n++) begin
                int op, sz;
                logic [AW-1:0] a;
                op = int'($urandom % 4);
                sz = int'($urandom % 4);
                a  = 32'($urandom % 128);
                if (($urandom % 4) != 0 || op == 2) a = a & ~32'((1 << sz) - 1);
                if (op == 1 && ($urandom % 2) == 0) a = last_lr;
                if (op == 0) last_lr = a;
                issue("R6 random", op, a, sz, {$urandom, $urandom});
                if (($urandom % 16) == 0) idle();
            end
        end
        idle();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule